// File: doc/BRIEF.md
# Command Queue Ring Controller

This block manages a command ring that lives in system memory and feeds an interrupt translation unit. Software sets up the ring with a base register, which holds the physical base address and a page-count size field. It then publishes new work by moving a write pointer, and it can set a global enable bit. All of this goes through a 64-bit register port that also accepts 32-bit half-register writes. The block owns the read pointer. While the read pointer differs from the write pointer, a fetch engine reads one 32-byte command at a time over a request/response memory port. It hands each good command to a decoder and then advances the read pointer, which wraps at the end of the ring.

The decoder in this block is a stub. It acknowledges each command one cycle after the command is presented. A fetch that comes back with an error is not dispatched: the command is dropped and the ring moves on. The base register is locked while the unit is enabled. An accepted base write empties the ring by zeroing both pointers.

The fetch engine has five states:
- FS_IDLE: waits for work. It moves to FS_ISSUE when the pointers differ and no base write is being accepted in the same cycle. On that move it latches the fetch address.
- FS_ISSUE: drives the memory request. It moves to FS_WAIT when the request is accepted.
- FS_WAIT: waits for the response. A good response moves it to FS_DISPATCH. An error response moves it to FS_ADVANCE.
- FS_DISPATCH: presents the command. It moves to FS_ADVANCE on the acknowledge.
- FS_ADVANCE: steps the read pointer and returns to FS_IDLE.

If a base write is accepted while a fetch is in flight, that fetch still completes, but its pointer step is suppressed.

Top module: `cmdq_ring_ctrl`

## Requirements
- R1: After reset, the control register reads 0x2 (enable 0, quiescent 1), and the base, write-pointer and read-pointer registers read 0. No memory request and no command valid are active.
- R2: Register word index `reg_word[2:1]` selects the register: 0 control, 1 base, 2 write pointer, 3 read pointer. With `reg_wide`=0, `reg_word[0]` selects the upper (1) or lower (0) 32-bit half. Only that half is written, from `reg_wdata[31:0]`, and a read returns that half in `reg_rdata[31:0]` with zeros above. The enable bit is written only by an access that covers the lower half.
- R3: The write-pointer and read-pointer registers hold only byte-offset bits [19:5]. Every other bit reads as zero, and written bits outside [19:5] are discarded.
- R4: A write-pointer value (after the R3 masking) at or above the ring size is dropped, and the register keeps its old value. A value of ring size minus 32 is accepted.
- R5: The ring size in bytes is (base[7:0]+1)*4096. After each command the read pointer advances by 32 and wraps to 0 when it reaches the ring size.
- R6: While the enable bit (control bit 0) is 1, writes to the base register are ignored, and neither the base nor the pointers change.
- R7: An accepted base write stores the value with bits [51:48] and [15:12] forced to zero, and sets both pointers to 0.
- R8: The engine issues one request at a time at address {base[47:12],12'b0} + read pointer. It presents the returned 256 bits on `cmd_data` with `cmd_valid` held until `cmd_ack`, and it issues no new request before that command completes. This runs whether or not the unit is enabled.
- R9: A fetch whose response has `mem_rsp_err`=1 is not presented on the command port, and the read pointer still advances past it.
- R10: Control bit 1 (quiescent) reads 1 exactly when the read pointer equals the write pointer.
- R11: Writes to the read-pointer register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit half access |
| reg_word | input | 3 | 32-bit word index within the register block |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational from reg_word/reg_wide |
| mem_req_valid | output | 1 | Command fetch request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 48 | Physical byte address of the 32-byte command |
| mem_rsp_valid | input | 1 | Fetch response valid |
| mem_rsp_err | input | 1 | Fetch response carries an error |
| mem_rsp_data | input | 256 | Fetched command |
| cmd_valid | output | 1 | Command presented to the decoder |
| cmd_data | output | 256 | Command contents |
| cmd_ack | output | 1 | Decoder stub acknowledge |

## Verification
A corrupted read pointer shows up at once in `mem_req_addr` on the next request, which the bench compares with its own ring model. It then shows up as a wrong command count or a wrong final read pointer once the ring drains. A lost or late wrap shows up on the first fetch past the ring end. A wrong lock or a missed pointer reset shows up on the register read that directly follows the base write. A wrong dispatch decision after an error shows up as an extra acknowledged command within two cycles of that response.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    // register index decoded from reg_word[2:1]
    localparam logic [1:0] RIDX_CTRL = 2'd0;
    localparam logic [1:0] RIDX_BASE = 2'd1;
    localparam logic [1:0] RIDX_WPTR = 2'd2;
    localparam logic [1:0] RIDX_RPTR = 2'd3;

    // control register bit positions
    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_QUIET_BIT = 1;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_ISSUE,
        FS_WAIT,
        FS_DISPATCH,
        FS_ADVANCE
    } fetch_state_t;

endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
    import cmdq_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int PAGE_SHIFT  = 12,
    parameter int SIZE_W      = 8,
    parameter int CMD_SHIFT   = 5,
    parameter int ALIGN_SHIFT = 16,
    parameter int PAD_W       = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr,
    input  logic                                 wide,
    input  logic [2:0]                           word,
    input  logic [63:0]                          wdata,
    input  logic                                 adv,
    output logic [63:0]                          rdata,
    output logic                                 flush,
    output logic                                 pending,
    output logic [ADDR_W-1:0]                    base_addr,
    output logic [PAGE_SHIFT+SIZE_W-1:0]         rptr
);
    localparam int OFF_W     = PAGE_SHIFT + SIZE_W;
    localparam int SLOT_W    = OFF_W - CMD_SHIFT;
    localparam int SUB_SHIFT = PAGE_SHIFT - CMD_SHIFT;

    logic [63:0]       base_q;
    logic              en_q;
    logic [SLOT_W-1:0] wslot_q;
    logic [SLOT_W-1:0] rslot_q;

    logic [1:0]        ridx;
    logic [63:0]       cur;
    logic [63:0]       merged;
    logic [63:0]       base_clean;
    logic [SLOT_W:0]   pages;
    logic [SLOT_W:0]   ring_slots;
    logic [SLOT_W-1:0] cand_slot;
    logic [SLOT_W-1:0] rslot_step;
    logic              quiet;
    logic              wr_base, base_ok, wptr_ok, ctrl_ok;

    assign ridx  = word[2:1];
    assign quiet = (rslot_q == wslot_q);

    // current value of the addressed register
    always_comb begin
        cur = '0;
        unique case (ridx)
            RIDX_CTRL: begin
                cur[CTRL_EN_BIT]    = en_q;
                cur[CTRL_QUIET_BIT] = quiet;
            end
            RIDX_BASE: cur = base_q;
            RIDX_WPTR: cur = 64'({wslot_q, {CMD_SHIFT{1'b0}}});
            RIDX_RPTR: cur = 64'({rslot_q, {CMD_SHIFT{1'b0}}});
            default:   cur = '0;
        endcase
    end

    // read path: full register, or one half in the low 32 bits
    always_comb begin
        if (wide)
            rdata = cur;
        else if (word[0])
            rdata = {32'h0, cur[63:32]};
        else
            rdata = {32'h0, cur[31:0]};
    end

    // write merge for half accesses
    always_comb begin
        if (wide)
            merged = wdata;
        else if (word[0])
            merged = {wdata[31:0], cur[31:0]};
        else
            merged = {cur[63:32], wdata[31:0]};
    end

    always_comb begin
        base_clean = merged;
        base_clean[ADDR_W+PAD_W-1:ADDR_W]      = '0;
        base_clean[ALIGN_SHIFT-1:PAGE_SHIFT]   = '0;
    end

    assign pages      = (SLOT_W+1)'(base_q[SIZE_W-1:0]) + (SLOT_W+1)'(1);
    assign ring_slots = pages << SUB_SHIFT;
    assign cand_slot  = merged[OFF_W-1:CMD_SHIFT];
    assign rslot_step = ({1'b0, rslot_q} + (SLOT_W+1)'(1) == ring_slots)
                        ? '0 : rslot_q + SLOT_W'(1);

    assign wr_base = wr && (ridx == RIDX_BASE);
    assign base_ok = wr_base && !en_q;
    assign wptr_ok = wr && (ridx == RIDX_WPTR) && ({1'b0, cand_slot} < ring_slots);
    assign ctrl_ok = wr && (ridx == RIDX_CTRL) && (wide || !word[0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            en_q    <= 1'b0;
            wslot_q <= '0;
            rslot_q <= '0;
        end else begin
            if (ctrl_ok)
                en_q <= wdata[CTRL_EN_BIT];
            if (base_ok) begin
                base_q  <= base_clean;
                wslot_q <= '0;
                rslot_q <= '0;
            end else begin
                if (wptr_ok)
                    wslot_q <= cand_slot;
                if (adv)
                    rslot_q <= rslot_step;
            end
        end
    end

    assign flush     = base_ok;
    assign pending   = !quiet;
    assign base_addr = {base_q[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    assign rptr      = {rslot_q, {CMD_SHIFT{1'b0}}};

    // R4: the write pointer never leaves the ring
    a_r4_wptr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, wslot_q} < ring_slots));

    // R5: the read pointer only steps by one command or returns to zero
    a_r5_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rslot_q) |-> ((rslot_q == $past(rslot_q) + SLOT_W'(1)) || (rslot_q == '0)));

    // R6: base is frozen while enabled
    a_r6_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_base && en_q) |=> $stable(base_q));

    // R7: accepted base write empties the ring
    a_r7_base_clears: assert property (@(posedge clk) disable iff (!rst_n)
        base_ok |=> (rslot_q == '0 && wslot_q == '0));

    // R11: read-pointer writes do not move it
    a_r11_rptr_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ridx == RIDX_RPTR && !adv) |=> $stable(rslot_q));

endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int OFF_W  = 20,
    parameter int CMD_W  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending,
    input  logic              flush,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  rptr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [CMD_W-1:0]  mem_rsp_data,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    input  logic              cmd_ack,
    output logic              adv
);
    fetch_state_t      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  data_q;
    logic              stale_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:     if (pending && !flush) state_d = FS_ISSUE;
            FS_ISSUE:    if (mem_req_ready)     state_d = FS_WAIT;
            FS_WAIT:     if (mem_rsp_valid)     state_d = mem_rsp_err ? FS_ADVANCE : FS_DISPATCH;
            FS_DISPATCH: if (cmd_ack)           state_d = FS_ADVANCE;
            FS_ADVANCE:                         state_d = FS_IDLE;
            default:                            state_d = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = (state_q == FS_ISSUE);
        cmd_valid     = (state_q == FS_DISPATCH);
        adv           = (state_q == FS_ADVANCE) && !stale_q && !flush;
        mem_req_addr  = addr_q;
        cmd_data      = data_q;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            stale_q <= 1'b0;
        end else begin
            if (state_q == FS_IDLE && pending && !flush)
                addr_q <= base_addr + ADDR_W'(rptr);
            if (state_q == FS_WAIT && mem_rsp_valid && !mem_rsp_err)
                data_q <= mem_rsp_data;
            if (state_q == FS_IDLE)
                stale_q <= 1'b0;
            else if (flush)
                stale_q <= 1'b1;
        end
    end

    // R8: a single command in flight
    a_r8_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cmd_valid);

    // R8: command held until acknowledged
    a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_data)));

    // R9: an errored fetch is never presented
    a_r9_err_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_WAIT && mem_rsp_valid && mem_rsp_err) |=> !cmd_valid);

    // R8: request address held while waiting for acceptance
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: rtl/cmdq_dec_stub.sv
module cmdq_dec_stub (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    output logic ack
);
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= valid && !ack;
    end

    // R8: acknowledge only a presented command
    a_r8_ack_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> valid);

endmodule

// File: rtl/cmdq_ring_ctrl.sv
module cmdq_ring_ctrl
    import cmdq_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int PAGE_SHIFT  = 12,
    parameter int SIZE_W      = 8,
    parameter int CMD_SHIFT   = 5,
    parameter int ALIGN_SHIFT = 16,
    parameter int PAD_W       = 4,
    localparam int OFF_W      = PAGE_SHIFT + SIZE_W,
    localparam int CMD_W      = 8 << CMD_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_wide,
    input  logic [2:0]        reg_word,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [CMD_W-1:0]  mem_rsp_data,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              cmd_ack
);
    logic              adv, flush, pending;
    logic [ADDR_W-1:0] base_addr;
    logic [OFF_W-1:0]  rptr;

    cmdq_regs #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .SIZE_W(SIZE_W),
        .CMD_SHIFT(CMD_SHIFT), .ALIGN_SHIFT(ALIGN_SHIFT), .PAD_W(PAD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wide(reg_wide), .word(reg_word),
        .wdata(reg_wdata), .adv(adv), .rdata(reg_rdata), .flush(flush),
        .pending(pending), .base_addr(base_addr), .rptr(rptr)
    );

    cmdq_fetch #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CMD_W(CMD_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .pending(pending), .flush(flush),
        .base_addr(base_addr), .rptr(rptr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ack(cmd_ack), .adv(adv)
    );

    cmdq_dec_stub u_dec (
        .clk(clk), .rst_n(rst_n), .valid(cmd_valid), .ack(cmd_ack)
    );

endmodule

// File: tb/cmdq_ring_ctrl_bench.sv
`timescale 1ns/1ps
module cmdq_ring_ctrl_bench;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         reg_wr = 0, reg_wide = 1;
    logic [2:0]   reg_word = 0;
    logic [63:0]  reg_wdata = 0;
    logic [63:0]  reg_rdata;
    logic         mem_req_valid, mem_req_ready;
    logic [47:0]  mem_req_addr;
    logic         mem_rsp_valid, mem_rsp_err;
    logic [255:0] mem_rsp_data;
    logic         cmd_valid, cmd_ack;
    logic [255:0] cmd_data;

    int n_chk = 0, n_fail = 0;
    int n_req = 0, n_disp = 0;
    int exp_slot = 0, exp_slots = 128;
    logic [47:0] exp_base = '0;
    logic [47:0] last_addr = '0;
    logic        last_err = 0;
    logic        err_on = 0, slow = 0, rdy = 1;
    logic [6:0]  err_slot = 0;
    logic        rsp_v = 0;
    logic [47:0] rsp_a = '0;

    always #2 clk = ~clk;

    cmdq_ring_ctrl u_cmdq_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
        .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ack(cmd_ack)
    );

    function automatic logic [255:0] pat(logic [47:0] a);
        return {8{a[31:0] ^ 32'h5A5A_0F0F}};
    endfunction

    function automatic logic [63:0] clean(logic [63:0] v);
        return v & ~(64'hF << 48) & ~(64'hF << 12);
    endfunction

    // memory model: one-cycle response latency
    always @(posedge clk) begin
        rdy   <= slow ? ~rdy : 1'b1;
        rsp_v <= mem_req_valid && mem_req_ready;
        rsp_a <= mem_req_addr;
    end
    assign mem_req_ready = rdy;
    assign mem_rsp_valid = rsp_v;
    assign mem_rsp_err   = rsp_v && err_on && (rsp_a[11:5] == err_slot);
    assign mem_rsp_data  = pat(rsp_a);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // port monitors
    always @(negedge clk) begin
        if (rst_n && mem_req_valid && mem_req_ready) begin
            logic [47:0] ea;
            ea = exp_base + 48'(exp_slot * 32);
            check(mem_req_addr == ea, "R8 fetch address", 64'(mem_req_addr), 64'(ea));
            last_addr = mem_req_addr;
            last_err  = err_on && (mem_req_addr[11:5] == err_slot);
            exp_slot  = (exp_slot + 1 == exp_slots) ? 0 : exp_slot + 1;
            n_req++;
        end
        if (rst_n && cmd_valid && cmd_ack) begin
            n_disp++;
            check(!last_err, "R9 errored command dispatched", 64'(last_addr), 64'(0));
            check(cmd_data == pat(last_addr), "R8 command data", cmd_data[63:0], pat(last_addr)[63:0]);
        end
    end

    task automatic wr(input logic [2:0] w, input logic [63:0] d, input logic wide);
        @(negedge clk);
        reg_word = w; reg_wdata = d; reg_wide = wide; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0; reg_wide = 1;
    endtask

    task automatic rd(input logic [2:0] w, input logic wide, output logic [63:0] v);
        @(negedge clk);
        reg_word = w; reg_wide = wide;
        #1 v = reg_rdata;
        reg_wide = 1;
    endtask

    task automatic wait_idle();
        logic [63:0] v;
        int n = 0;
        do begin
            rd(3'd0, 1, v);
            n++;
        end while (!v[1] && n < 20000);
    endtask

    task automatic set_base(input logic [63:0] raw);
        logic [63:0] s;
        s = clean(raw);
        wr(3'd2, raw, 1);
        exp_base  = s[47:0] & ~48'hFFF;
        exp_slots = (int'(s[7:0]) + 1) * 128;
        exp_slot  = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired act=%0d exp=%0d", n_chk, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] v, raw, cur_base;
        int ring, n0, d0;

        repeat (3) @(posedge clk);
        rst_n = 1;

        // R1 reset state
        rd(3'd0, 1, v); check(v == 64'h2, "R1 ctrl reset", v, 64'h2);
        rd(3'd2, 1, v); check(v == 0, "R1 base reset", v, 0);
        rd(3'd4, 1, v); check(v == 0, "R1 wptr reset", v, 0);
        rd(3'd6, 1, v); check(v == 0, "R1 rptr reset", v, 0);
        check(!mem_req_valid && !cmd_valid, "R1 idle outputs", 64'({mem_req_valid, cmd_valid}), 0);

        // sweep of ring sizes 0..3
        cur_base = 0;
        for (int s = 0; s < 4; s++) begin
            slow = s[0];
            raw = (64'h00F7_89AB_CDEF_F000 ^ (64'(s) << 20)) | 64'(s);
            set_base(raw);
            cur_base = clean(raw);
            rd(3'd2, 1, v); check(v == cur_base, "R7 base masking", v, cur_base);
            rd(3'd4, 1, v); check(v == 0, "R7 wptr cleared", v, 0);
            rd(3'd6, 1, v); check(v == 0, "R7 rptr cleared", v, 0);
            ring = (s + 1) * 4096;
            n0 = n_req; d0 = n_disp;
            wr(3'd4, 64'(ring - 32), 1);
            rd(3'd4, 1, v); check(v == 64'(ring - 32), "R4 last slot accepted", v, 64'(ring - 32));
            wait_idle();
            rd(3'd6, 1, v); check(v == 64'(ring - 32), "R5 rptr after fill", v, 64'(ring - 32));
            check(n_req - n0 == ring / 32 - 1, "R8 fetch count", 64'(n_req - n0), 64'(ring / 32 - 1));
            wr(3'd4, 64'd32, 1);
            wait_idle();
            rd(3'd6, 1, v); check(v == 64'd32, "R5 wrap", v, 64'd32);
            check(n_disp - d0 == ring / 32 + 1, "R5 commands across wrap", 64'(n_disp - d0), 64'(ring / 32 + 1));
            wr(3'd4, 64'(ring), 1);
            rd(3'd4, 1, v); check(v == 64'd32, "R4 ring size dropped", v, 64'd32);
            wr(3'd4, 64'(ring + 64), 1);
            rd(3'd4, 1, v); check(v == 64'd32, "R4 beyond ring dropped", v, 64'd32);
        end
        slow = 0;

        // R2 half accesses on the base register
        wr(3'd2, {32'hDEAD_BEEF, 32'h0003_F001}, 0);
        cur_base = {cur_base[63:32], 32'h0003_0001};
        rd(3'd2, 1, v); check(v == cur_base, "R2 low half write", v, cur_base);
        wr(3'd3, {32'h0, 32'h0012_0034}, 0);
        cur_base = {32'h0010_0034, 32'h0003_0001};
        exp_base = 48'h0034_0003_0000; exp_slots = 256; exp_slot = 0;
        rd(3'd3, 0, v); check(v == 64'h0010_0034, "R2 high half read", v, 64'h0010_0034);
        rd(3'd2, 0, v); check(v == 64'h0003_0001, "R2 low half read", v, 64'h0003_0001);
        rd(3'd2, 1, v); check(v == cur_base, "R2 full read", v, cur_base);

        wr(3'd4, 64'h40, 1);
        wait_idle();
        wr(3'd5, 64'hFFFF_FFFF, 0);
        rd(3'd4, 1, v); check(v == 64'h40, "R2 wptr high half no effect", v, 64'h40);
        rd(3'd5, 0, v); check(v == 0, "R3 wptr high half zero", v, 0);

        // R3 pointer masking
        wr(3'd4, 64'hFFFF_FFFF_FFF0_00BF, 1);
        rd(3'd4, 1, v); check(v == 64'hA0, "R3 wptr masked", v, 64'hA0);
        wait_idle();
        rd(3'd6, 1, v); check(v == 64'hA0, "R3 rptr masked", v, 64'hA0);

        // R10 quiescent
        wr(3'd4, 64'h100, 1);
        rd(3'd0, 1, v); check(v == 64'h0, "R10 busy", v, 0);
        wait_idle();
        rd(3'd0, 1, v); check(v == 64'h2, "R10 quiescent", v, 64'h2);

        // R6 lock while enabled
        wr(3'd0, 64'h1, 0);
        rd(3'd0, 1, v); check(v == 64'h3, "R6 enabled", v, 64'h3);
        wr(3'd2, 64'h1234_0000, 1);
        rd(3'd2, 1, v); check(v == cur_base, "R6 base locked", v, cur_base);
        rd(3'd4, 1, v); check(v == 64'h100, "R6 wptr kept", v, 64'h100);
        wr(3'd4, 64'h140, 1);
        wait_idle();
        rd(3'd6, 1, v); check(v == 64'h140, "R8 fetch while enabled", v, 64'h140);
        wr(3'd1, 64'h0, 0);
        rd(3'd0, 1, v); check(v == 64'h3, "R2 upper ctrl half no effect", v, 64'h3);
        wr(3'd0, 64'h0, 1);
        rd(3'd0, 1, v); check(v == 64'h2, "R6 disabled", v, 64'h2);

        // R11 read pointer is read-only
        n0 = n_req;
        wr(3'd6, 64'h20, 1);
        repeat (4) @(negedge clk);
        rd(3'd6, 1, v); check(v == 64'h140, "R11 rptr write ignored", v, 64'h140);
        check(n_req == n0, "R11 no fetch started", 64'(n_req - n0), 0);

        // R9 error skip, including on the last slot before wrap
        set_base(64'h0005_0000);
        rd(3'd6, 1, v); check(v == 0, "R7 rptr reset", v, 0);
        err_on = 1; err_slot = 7'd3;
        n0 = n_req; d0 = n_disp;
        wr(3'd4, 64'd320, 1);
        wait_idle();
        check(n_req - n0 == 10, "R9 fetches", 64'(n_req - n0), 10);
        check(n_disp - d0 == 9, "R9 dispatched", 64'(n_disp - d0), 9);
        rd(3'd6, 1, v); check(v == 64'd320, "R9 rptr advanced", v, 64'd320);
        err_slot = 7'd127;
        n0 = n_req; d0 = n_disp;
        wr(3'd4, 64'd32, 1);
        wait_idle();
        check(n_req - n0 == 119, "R9 fetches over wrap", 64'(n_req - n0), 119);
        check(n_disp - d0 == 118, "R9 skip last slot", 64'(n_disp - d0), 118);
        rd(3'd6, 1, v); check(v == 64'd32, "R9 R5 wrap after skip", v, 64'd32);
        err_on = 0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule